// File: doc/BRIEF.md
# Eight-Stage Superpipelined Integer Datapath

This block is a small in-order integer pipeline split into eight stages: two instruction-fetch stages, a combined register-read and decode stage, a single-cycle execute stage, two data-access stages, a tag-check stage and a final writeback stage. The data-access and tag-check stages carry the execute result forward without changing it. Register state changes only at writeback. `clk` is the fast internal clock, which runs at twice a nominal external rate. One instruction enters the pipe on every `clk` edge, so two enter per external period.

The pipe presents a word address to an instruction memory on the cycle it asserts `imem_req`. The memory returns the word on `imem_rdata` one clock later. That makes the two fetch stages line up with a one-cycle memory. The execute stage picks up each operand from the nearest older instruction still in flight that writes the same register. The candidates are in the first data-access, second data-access, tag-check and writeback stages, and the youngest match wins. So an instruction that depends on the one just before it issues on the next cycle with no stall.

Each retiring register write appears on the writeback outputs in the cycle it updates the register file. This is the port through which results are observed.

Top module: `sp_pipe`

## Requirements
- R1: While reset is held, `imem_req` stays low even if `fetch_en` is high, `wb_valid` stays low, and `imem_addr` is 0. After release, nothing retires until an instruction has been fetched.
- R2: An instruction whose address is presented with `imem_req` high in cycle t shows up on `wb_valid`/`wb_rd`/`wb_data` in cycle t+7, the eighth stage.
- R3: Fetch runs on every cycle `fetch_en` is high, with the address stepping by one from 0 after reset. Instructions retire in program order, and back-to-back instructions retire on consecutive cycles even when each depends on the one before it.
- R4: The word encodes the opcode in bits [31:28], the destination in [27:24], the first source in [23:20], the second source in [19:16], and a 16-bit immediate in [15:0]. The opcodes are:
  - 1: add.
  - 2: subtract (first minus second, modulo 2^DATA_W).
  - 3: AND.
  - 4: OR.
  - 5: XOR.
  - 6: pass the immediate, zero-extended.
- R5: A source that names the destination of the immediately preceding instruction gets that instruction's new value. An example is a subtract writing r3 followed at once by an OR reading r3.
- R6: Producers two, three and four instructions ahead are forwarded correctly. When several in-flight instructions write the same register, the youngest one supplies the value.
- R7: A producer five or more instructions ahead supplies its value through the register file. This includes the case where its write happens in the same cycle as the consumer's register read.
- R8: Register r0 always reads as 0. An instruction with destination r0 never raises `wb_valid` and is never forwarded.
- R9: A cycle with `fetch_en` low inserts a bubble and holds the fetch address. A bubble never retires and never disturbs forwarding to the instructions around it.
- R10: Opcodes 0 and 7 to 15 write nothing: they raise no `wb_valid` and leave the destination register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal (double-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_en | input | 1 | An instruction may be fetched this cycle |
| imem_req | output | 1 | Fetch address valid this cycle |
| imem_addr | output | ADDR_W | Word address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word, returned one cycle after the request |
| wb_valid | output | 1 | A register write retires this cycle |
| wb_rd | output | 4 | Destination register of the retiring write |
| wb_data | output | DATA_W | Value written to that register |

## Verification
A wrong forwarding choice or stale register read shows up at the ports as a wrong `wb_data` on the consumer, exactly seven cycles after that consumer was fetched. So bypass distances one to six are each driven directly, along with several writers of one register in flight. A pipe that drops or duplicates a stage slot, or lets a bubble carry state, shows up as a retire in the wrong cycle or a missing or extra `wb_valid`. The bench therefore compares every retire against the fetch cycle plus seven. It also compares the number of retires against the number of writing instructions in the program.

// File: rtl/sp_pipe_pkg.sv
package sp_pipe_pkg;

  localparam int RA_W  = 4;
  localparam int N_REG = 2 ** RA_W;

  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_PASS = 4'd6;

  function automatic logic op_writes(input logic [3:0] op);
    return (op >= OP_ADD) && (op <= OP_PASS);
  endfunction

endpackage

// File: rtl/sp_fetch.sv
module sp_fetch #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  output logic              is_vld
);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              is_q, is_d;

  // no request may leave while the synchronised reset is active
  assign imem_req  = fetch_en && rst_n;
  assign imem_addr = pc_q;
  assign is_vld    = is_q;

  always_comb begin
    pc_d = pc_q;
    if (imem_req) pc_d = pc_q + 1'b1;
    is_d = imem_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      is_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      is_q <= is_d;
    end
  end

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |=> (imem_addr == ADDR_W'($past(imem_addr) + 1'b1)));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !imem_req |=> $stable(imem_addr));

endmodule

// File: rtl/sp_regfile.sv
module sp_regfile import sp_pipe_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RA_W-1:0]   wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [RA_W-1:0]   ra1,
  input  logic [RA_W-1:0]   ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);

  logic [DATA_W-1:0] mem_q [N_REG];
  logic [DATA_W-1:0] mem_d [N_REG];

  // read with write-through: a write in this cycle is seen by this read
  function automatic logic [DATA_W-1:0] rd_port(input logic [RA_W-1:0] ra);
    if (ra == '0)              return '0;
    else if (we && (wa == ra)) return wd;
    else                       return mem_q[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);

  always_comb begin
    for (int i = 0; i < N_REG; i++) mem_d[i] = mem_q[i];
    if (we && (wa != '0)) mem_d[wa] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_REG; i++) mem_q[i] <= mem_d[i];
    end
  end

  p_no_r0_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wa != '0));

  p_r0_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));

endmodule

// File: rtl/sp_bypass.sv
module sp_bypass import sp_pipe_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int N_SRC  = 4
) (
  input  logic [RA_W-1:0]               rs,
  input  logic [DATA_W-1:0]             rf_val,
  input  logic [N_SRC-1:0]              src_wr,
  input  logic [N_SRC-1:0][RA_W-1:0]    src_rd,
  input  logic [N_SRC-1:0][DATA_W-1:0]  src_data,
  output logic [DATA_W-1:0]             val
);

  // index 0 is the youngest producer; scanning oldest first lets it win
  always_comb begin
    val = rf_val;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (src_wr[s] && (src_rd[s] == rs) && (rs != '0)) val = src_data[s];
    end
  end

endmodule

// File: rtl/sp_alu.sv
module sp_alu import sp_pipe_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [15:0]       imm,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PASS: y = DATA_W'(imm);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sp_pipe.sv
module sp_pipe import sp_pipe_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              wb_valid,
  output logic [RA_W-1:0]   wb_rd,
  output logic [DATA_W-1:0] wb_data
);

  // result-carrying stages after execute: DF, DS, TC, WB
  localparam int N_RES = 4;
  localparam int N_OPND = 2;
  localparam int LAST = N_RES - 1;

  // ---------------- reset synchroniser ----------------
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // ---------------- IF / IS ----------------
  logic is_vld;

  sp_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .fetch_en  (fetch_en),
    .imem_req  (imem_req),
    .imem_addr (imem_addr),
    .is_vld    (is_vld)
  );

  // ---------------- RF: register read + decode ----------------
  logic        rf_vld_q, rf_vld_d;
  logic [31:0] rf_ir_q, rf_ir_d;

  always_comb begin
    rf_vld_d = is_vld;
    rf_ir_d  = rf_ir_q;
    if (is_vld) rf_ir_d = imem_rdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rf_vld_q <= 1'b0;
      rf_ir_q  <= '0;
    end else begin
      rf_vld_q <= rf_vld_d;
      rf_ir_q  <= rf_ir_d;
    end
  end

  logic [3:0]      rf_op;
  logic [RA_W-1:0] rf_rd;
  logic [RA_W-1:0] rf_rs [N_OPND];
  logic [15:0]     rf_imm;

  assign rf_op    = rf_ir_q[31:28];
  assign rf_rd    = rf_ir_q[27:24];
  assign rf_rs[0] = rf_ir_q[23:20];
  assign rf_rs[1] = rf_ir_q[19:16];
  assign rf_imm   = rf_ir_q[15:0];

  logic [N_RES-1:0]             res_wr;
  logic [N_RES-1:0][RA_W-1:0]   res_rd;
  logic [N_RES-1:0][DATA_W-1:0] res_data;
  logic [DATA_W-1:0]            rf_val [N_OPND];

  sp_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (res_wr[LAST]),
    .wa    (res_rd[LAST]),
    .wd    (res_data[LAST]),
    .ra1   (rf_rs[0]),
    .ra2   (rf_rs[1]),
    .rd1   (rf_val[0]),
    .rd2   (rf_val[1])
  );

  // ---------------- EX ----------------
  logic              ex_vld_q, ex_vld_d;
  logic [3:0]        ex_op_q, ex_op_d;
  logic [RA_W-1:0]   ex_rd_q, ex_rd_d;
  logic [15:0]       ex_imm_q, ex_imm_d;
  logic [RA_W-1:0]   ex_rs_q  [N_OPND];
  logic [RA_W-1:0]   ex_rs_d  [N_OPND];
  logic [DATA_W-1:0] ex_raw_q [N_OPND];
  logic [DATA_W-1:0] ex_raw_d [N_OPND];

  always_comb begin
    ex_vld_d = rf_vld_q;
    ex_op_d  = ex_op_q;
    ex_rd_d  = ex_rd_q;
    ex_imm_d = ex_imm_q;
    for (int k = 0; k < N_OPND; k++) begin
      ex_rs_d[k]  = ex_rs_q[k];
      ex_raw_d[k] = ex_raw_q[k];
    end
    if (rf_vld_q) begin
      ex_op_d  = rf_op;
      ex_rd_d  = rf_rd;
      ex_imm_d = rf_imm;
      for (int k = 0; k < N_OPND; k++) begin
        ex_rs_d[k]  = rf_rs[k];
        ex_raw_d[k] = rf_val[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ex_vld_q <= 1'b0;
      ex_op_q  <= '0;
      ex_rd_q  <= '0;
      ex_imm_q <= '0;
      for (int k = 0; k < N_OPND; k++) begin
        ex_rs_q[k]  <= '0;
        ex_raw_q[k] <= '0;
      end
    end else begin
      ex_vld_q <= ex_vld_d;
      ex_op_q  <= ex_op_d;
      ex_rd_q  <= ex_rd_d;
      ex_imm_q <= ex_imm_d;
      for (int k = 0; k < N_OPND; k++) begin
        ex_rs_q[k]  <= ex_rs_d[k];
        ex_raw_q[k] <= ex_raw_d[k];
      end
    end
  end

  logic [DATA_W-1:0] opnd [N_OPND];

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    sp_bypass #(.DATA_W(DATA_W), .N_SRC(N_RES)) u_byp (
      .rs       (ex_rs_q[k]),
      .rf_val   (ex_raw_q[k]),
      .src_wr   (res_wr),
      .src_rd   (res_rd),
      .src_data (res_data),
      .val      (opnd[k])
    );
  end

  logic [DATA_W-1:0] alu_y;
  logic              ex_wr;

  sp_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (ex_op_q),
    .a   (opnd[0]),
    .b   (opnd[1]),
    .imm (ex_imm_q),
    .y   (alu_y)
  );

  assign ex_wr = ex_vld_q && op_writes(ex_op_q) && (ex_rd_q != '0);

  // ---------------- DF / DS / TC / WB result chain ----------------
  logic [N_RES-1:0]             res_wr_d;
  logic [N_RES-1:0][RA_W-1:0]   res_rd_d;
  logic [N_RES-1:0][DATA_W-1:0] res_data_d;

  always_comb begin
    res_wr_d[0]   = ex_wr;
    res_rd_d[0]   = res_rd[0];
    res_data_d[0] = res_data[0];
    if (ex_wr) begin
      res_rd_d[0]   = ex_rd_q;
      res_data_d[0] = alu_y;
    end
    for (int s = 1; s < N_RES; s++) begin
      res_wr_d[s]   = res_wr[s-1];
      res_rd_d[s]   = res_rd[s];
      res_data_d[s] = res_data[s];
      if (res_wr[s-1]) begin
        res_rd_d[s]   = res_rd[s-1];
        res_data_d[s] = res_data[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_wr   <= '0;
      res_rd   <= '0;
      res_data <= '0;
    end else begin
      res_wr   <= res_wr_d;
      res_rd   <= res_rd_d;
      res_data <= res_data_d;
    end
  end

  assign wb_valid = res_wr[LAST];
  assign wb_rd    = res_rd[LAST];
  assign wb_data  = res_data[LAST];

  p_retire_latency_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    wb_valid |-> $past(imem_req, 7));

  p_wb_nonzero_dst_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    wb_valid |-> (wb_rd != '0));

endmodule

// File: tb/sp_pipe_bench.sv
module sp_pipe_bench;

  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_en = 1'b0;
  logic          imem_req;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata = '0;
  logic          wb_valid;
  logic [3:0]    wb_rd;
  logic [DW-1:0] wb_data;

  sp_pipe #(.DATA_W(DW), .ADDR_W(AW)) u_sp_pipe (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [31:0] prog [64];
  int          gap  [64];
  int          fcyc [64];
  int          n_prog = 0;
  logic [3:0]  lg_rd   [64];
  logic [31:0] lg_data [64];
  int          lg_cyc  [64];
  int          n_log = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // instruction memory with one cycle of latency
  always @(posedge clk) if (imem_req) imem_rdata <= prog[imem_addr];

  always @(negedge clk) begin
    if (rst_n && wb_valid && n_log < 64) begin
      lg_rd[n_log]   = wb_rd;
      lg_data[n_log] = wb_data;
      lg_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] op, input int rd,
                                      input int rs1, input int rs2,
                                      input logic [15:0] imm);
    return {op, 4'(rd), 4'(rs1), 4'(rs2), imm};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin prog[i] = '0; gap[i] = 0; end
    n_prog = 0;
  endtask

  task automatic put(input logic [31:0] w);
    prog[n_prog] = w;
    n_prog++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_log = 0;
  endtask

  // run the loaded program, then compare every retire with an ISA model
  task automatic run(input string tag);
    logic [31:0] rr [16];
    logic [31:0] a, b, v;
    logic [3:0]  op;
    int          rd, k;
    do_reset();
    for (int i = 0; i < n_prog; i++) begin
      if (gap[i] > 0) begin
        fetch_en = 1'b0;
        repeat (gap[i]) @(negedge clk);
      end
      fetch_en = 1'b1;
      fcyc[i] = cyc;
      @(negedge clk);
    end
    fetch_en = 1'b0;
    repeat (12) @(negedge clk);
    for (int r = 0; r < 16; r++) rr[r] = '0;
    k = 0;
    for (int i = 0; i < n_prog; i++) begin
      op = prog[i][31:28];
      rd = int'(prog[i][27:24]);
      a  = rr[prog[i][23:20]];
      b  = rr[prog[i][19:16]];
      case (op)
        4'd1: v = a + b;
        4'd2: v = a - b;
        4'd3: v = a & b;
        4'd4: v = a | b;
        4'd5: v = a ^ b;
        4'd6: v = {16'h0, prog[i][15:0]};
        default: v = '0;
      endcase
      if (op >= 4'd1 && op <= 4'd6 && rd != 0) begin
        rr[rd] = v;
        if (k < n_log) begin
          chk(tag, $sformatf("instr %0d dst", i), 32'(lg_rd[k]), 32'(rd));
          chk(tag, $sformatf("instr %0d data", i), lg_data[k], v);
          chk("R2", $sformatf("%s instr %0d retire cycle", tag, i),
              32'(lg_cyc[k]), 32'(fcyc[i] + 7));
        end
        k++;
      end
    end
    chk(tag, "number of retires", 32'(n_log), 32'(k));
  endtask

  // R1: reset behaviour
  task automatic t_reset();
    rst_n = 1'b0;
    fetch_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "imem_req in reset", 32'(imem_req), 32'd0);
    chk("R1", "wb_valid in reset", 32'(wb_valid), 32'd0);
    chk("R1", "imem_addr in reset", 32'(imem_addr), 32'd0);
    fetch_en = 1'b0;
    rst_n = 1'b1;
    n_log = 0;
    repeat (12) @(negedge clk);
    chk("R1", "retires with no fetch", 32'(n_log), 32'd0);
    chk("R1", "imem_addr idle", 32'(imem_addr), 32'd0);
  endtask

  // R4 R2: every operation and its encoding
  task automatic t_ops();
    clear_prog();
    put(enc(4'd6, 1, 0, 0, 16'h1234));
    put(enc(4'd6, 2, 0, 0, 16'h00F0));
    put(enc(4'd1, 3, 1, 2, 16'h0));
    put(enc(4'd2, 4, 2, 1, 16'h0));
    put(enc(4'd3, 5, 1, 2, 16'h0));
    put(enc(4'd4, 6, 1, 2, 16'h0));
    put(enc(4'd5, 7, 1, 2, 16'h0));
    put(enc(4'd6, 8, 0, 0, 16'hFFFF));
    put(enc(4'd1, 9, 8, 4, 16'h0));
    run("R4");
  endtask

  // R5 R3: distance-1 dependency and dependent chain
  task automatic t_dep();
    clear_prog();
    put(enc(4'd6, 1, 0, 0, 16'd9));
    put(enc(4'd6, 2, 0, 0, 16'h40));
    put(enc(4'd6, 4, 0, 0, 16'h100));
    put(enc(4'd2, 3, 2, 1, 16'h0));
    put(enc(4'd4, 5, 3, 4, 16'h0));
    put(enc(4'd1, 6, 5, 3, 16'h0));
    put(enc(4'd1, 6, 6, 6, 16'h0));
    put(enc(4'd5, 7, 6, 6, 16'h0));
    run("R5");
    chk("R3", "back-to-back retire spacing", 32'(lg_cyc[4] - lg_cyc[3]), 32'd1);
  endtask

  // R6: distances 2..4 and youngest producer wins
  task automatic t_near();
    clear_prog();
    for (int d = 2; d <= 4; d++) begin
      put(enc(4'd6, 1, 0, 0, 16'(d * 11)));
      for (int f = 0; f < d - 1; f++) put(enc(4'd6, 9, 0, 0, 16'(d + f)));
      put(enc(4'd1, 10, 1, 1, 16'h0));
    end
    put(enc(4'd6, 11, 0, 0, 16'd1));
    put(enc(4'd6, 11, 0, 0, 16'd2));
    put(enc(4'd6, 11, 0, 0, 16'd3));
    put(enc(4'd1, 12, 11, 0, 16'h0));
    put(enc(4'd6, 13, 0, 0, 16'd4));
    put(enc(4'd1, 12, 0, 11, 16'h0));
    run("R6");
  endtask

  // R7: distances 5, 6 and 8 come from the register file
  task automatic t_far();
    clear_prog();
    for (int d = 5; d <= 8; d += 1) begin
      if (d != 7) begin
        put(enc(4'd6, 2, 0, 0, 16'(d * 3 + 1)));
        for (int f = 0; f < d - 1; f++) put(enc(4'd6, 9, 0, 0, 16'(f)));
        put(enc(4'd2, 10, 2, 9, 16'h0));
      end
    end
    run("R7");
  endtask

  // R8: r0 is hard zero
  task automatic t_zero();
    clear_prog();
    put(enc(4'd6, 0, 0, 0, 16'd5));
    put(enc(4'd1, 1, 0, 0, 16'h0));
    put(enc(4'd6, 2, 0, 0, 16'd7));
    put(enc(4'd1, 0, 2, 2, 16'h0));
    put(enc(4'd1, 3, 0, 2, 16'h0));
    put(enc(4'd4, 4, 0, 0, 16'h0));
    run("R8");
  endtask

  // R9: bubbles from fetch_en low
  task automatic t_bubble();
    clear_prog();
    put(enc(4'd6, 1, 0, 0, 16'd3));
    put(enc(4'd1, 2, 1, 1, 16'h0));
    put(enc(4'd1, 3, 2, 1, 16'h0));
    put(enc(4'd1, 4, 3, 3, 16'h0));
    put(enc(4'd5, 5, 4, 1, 16'h0));
    put(enc(4'd2, 6, 5, 2, 16'h0));
    gap[1] = 1;
    gap[2] = 2;
    gap[3] = 5;
    gap[5] = 3;
    run("R9");
  endtask

  // R10: undefined opcodes leave state untouched
  task automatic t_illegal();
    clear_prog();
    put(enc(4'd6, 1, 0, 0, 16'h55));
    put(enc(4'd7, 1, 1, 1, 16'hAAAA));
    put(enc(4'd15, 1, 1, 1, 16'h1111));
    put(enc(4'd0, 1, 1, 1, 16'h2222));
    put(enc(4'd1, 2, 1, 0, 16'h0));
    put(enc(4'd9, 2, 0, 0, 16'h0));
    put(enc(4'd4, 3, 2, 0, 16'h0));
    run("R10");
  endtask

  initial begin
    t_reset();
    t_ops();
    t_dep();
    t_near();
    t_far();
    t_zero();
    t_bubble();
    t_illegal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule